// File: doc/BRIEF.md
# Per-Peripheral Interrupt Accumulator

This block gathers interrupt events from a set of peripheral slots and folds them into a two-level summary. Each slot, addressed by an 8-bit slot number, keeps eight sticky pending bits that are set by one-cycle event pulses. Software clears them by writing a one to each bit it wants to drop. Each slot also has an enable bit and a small owner field. A slot that is enabled and has any pending bit contributes one summary bit. That bit is routed to the accumulated status words of the environment named by the slot's owner field. Each accumulated word covers 32 consecutive slots.

Every owner gets its own level-sensitive, active-high interrupt output. That output stays high while any of its accumulated bits is set. An interrupt handler reads its owner's accumulated words to find the active slots. It reads each such slot's pending status and writes the same value to the slot's clear register. All registers sit behind a simple word-addressed write port with a combinational read-back. The number of slots (up to 256) and the number of owners (up to 8) are parameters.

Top module: `apid_irq_accum`

## Requirements
- R1: A cycle with `rst_n` low clears every pending bit, every enable bit and every owner field, so every `irq_out` bit is 0 and every register reads 0 after reset.
- R2: A high bit on `evt_pulse[8*s+b]` for one cycle sets pending bit b of slot s at the next clock edge. The bit stays set until it is cleared. The pending status of slot s reads at address 0x600 + 4*s in bits [7:0].
- R3: A write to address 0xA00 + 4*s clears exactly those pending bits of slot s whose write-data bit in [7:0] is 1. A write-data bit of 0 leaves its pending bit unchanged, and the clear register reads 0.
- R4: When an event pulse and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R5: Writing 1 or 0 to bit 0 at address 0x200 + 4*s enables or disables slot s. The enable bit reads back in bit 0.
- R6: Bits [2:0] written at address 0xE00 + 4*s select the owner of slot s. The owner reads back in bits [2:0], limited to the owner-index width.
- R7: The accumulated word for owner m and group g reads at address 32*m + 4*g. Its bit j is 1 exactly when slot 32*g + j has a pending bit set, is enabled, and has owner m.
- R8: `irq_out[m]` is the OR of all accumulated words of owner m. It follows register state with no extra cycle of delay.
- R9: Writes to pending-status addresses and to accumulated-word addresses change no state.
- R10: Reads of addresses that map to no existing slot, group or register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_pulse | input | N_SLOT*8 | Event pulses; bits [8*s+7:8*s] belong to slot s |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 13 | Byte address of the register accessed (low two bits ignored) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq_out | output | N_OWNER | Level interrupt, one bit per owner |

## Verification
Wrong internal state shows at the ports in the cycle after the edge that stores it. A lost or stuck pending bit, a bad enable, or a misrouted owner field changes the pending-status read or the owner's accumulated word. It also changes the level of that owner's `irq_out` straight after the update. The bench therefore checks the status read, the accumulated word and `irq_out` together after each write or event. A fault that moves a slot to another owner then shows on two outputs at once. The simultaneous set-and-clear case and the read-only regions get their own checks. A silent priority or write-decode fault would otherwise only show up much later, as an interrupt that is missed or never drops.

// File: rtl/apid_irq_pkg.sv
// Package: shared address map and region type for the interrupt accumulator.
// Assumes 4-byte register stride and a fixed 256-slot span per region.
package apid_irq_pkg;
    localparam int          ADDR_W      = 13;
    localparam int          SRC_BITS    = 8;
    localparam int          GROUP_BITS  = 32;
    localparam int          MAX_SLOT    = 256;
    localparam logic [12:0] BASE_EN     = 13'h0200;
    localparam logic [12:0] BASE_STAT   = 13'h0600;
    localparam logic [12:0] BASE_CLR    = 13'h0A00;
    localparam logic [12:0] BASE_OWN    = 13'h0E00;
    localparam logic [12:0] REGION_SPAN = 13'h0400;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_ACC,
        RGN_EN,
        RGN_STAT,
        RGN_CLR,
        RGN_OWN
    } region_e;
endpackage

// File: rtl/apid_reg_decode.sv
// Address decoder: splits a byte address into region, slot index and
// accumulated-word coordinates. Purely combinational; assumes the
// accumulated-word region (32 bytes per owner) lies below BASE_EN.
module apid_reg_decode
    import apid_irq_pkg::*;
#(
    parameter int N_SLOT  = 64,
    parameter int N_OWNER = 8,
    localparam int OWN_W  = (N_OWNER > 1) ? $clog2(N_OWNER) : 1,
    localparam int N_GROUP = (N_SLOT + GROUP_BITS - 1) / GROUP_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [7:0]        slot_idx,
    output logic              slot_ok,
    output logic [OWN_W-1:0]  acc_owner,
    output logic [2:0]        acc_group,
    output logic              group_ok
);
    localparam logic [12:0] ACC_END   = 13'(32 * N_OWNER);
    localparam logic [8:0]  SLOT_LIM  = 9'(N_SLOT);
    localparam logic [3:0]  GROUP_LIM = 4'(N_GROUP);

    logic [12:0] offset;

    // Region match and offset from the region base.
    always_comb begin
        region = RGN_NONE;
        offset = '0;
        if (addr < ACC_END) begin
            region = RGN_ACC;
        end else if (addr >= BASE_EN && addr < BASE_EN + REGION_SPAN) begin
            region = RGN_EN;
            offset = addr - BASE_EN;
        end else if (addr >= BASE_STAT && addr < BASE_STAT + REGION_SPAN) begin
            region = RGN_STAT;
            offset = addr - BASE_STAT;
        end else if (addr >= BASE_CLR && addr < BASE_CLR + REGION_SPAN) begin
            region = RGN_CLR;
            offset = addr - BASE_CLR;
        end else if (addr >= BASE_OWN && addr < BASE_OWN + REGION_SPAN) begin
            region = RGN_OWN;
            offset = addr - BASE_OWN;
        end
    end

    // Slot and accumulated-word coordinates with range flags.
    always_comb begin
        slot_idx  = offset[9:2];
        slot_ok   = ({1'b0, slot_idx} < SLOT_LIM);
        acc_owner = addr[5 +: OWN_W];
        acc_group = addr[4:2];
        group_ok  = ({1'b0, acc_group} < GROUP_LIM);
    end
endmodule

// File: rtl/apid_slot_cell.sv
// One peripheral slot: eight sticky pending bits (set by pulses, cleared by
// write-one), an enable bit and an owner field. Assumes strobes are already
// decoded for this slot. A set in the same cycle as a clear wins.
module apid_slot_cell #(
    parameter int SRC_BITS = 8,
    parameter int OWN_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SRC_BITS-1:0] evt_i,
    input  logic                clr_we_i,
    input  logic                en_we_i,
    input  logic                own_we_i,
    input  logic [31:0]         wdata_i,
    output logic [SRC_BITS-1:0] pend_o,
    output logic                en_o,
    output logic [OWN_W-1:0]    own_o
);
    logic [SRC_BITS-1:0] pend_q;
    logic [SRC_BITS-1:0] clr_mask;
    logic                en_q;
    logic [OWN_W-1:0]    own_q;

    // Bits to drop this cycle.
    always_comb clr_mask = clr_we_i ? wdata_i[SRC_BITS-1:0] : '0;

    // Pending bits: clear first, then OR in new events so set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | evt_i;
    end

    // Enable and owner fields, written by the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            own_q <= '0;
        end else begin
            if (en_we_i)  en_q  <= wdata_i[0];
            if (own_we_i) own_q <= wdata_i[OWN_W-1:0];
        end
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign own_o  = own_q;

    // R2 / R4: every pulsed bit is pending after the edge, clear or not.
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));
    // R3: cleared bits without a coincident event are gone after the edge.
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((pend_q & $past(wdata_i[SRC_BITS-1:0] & ~evt_i)) == '0));
    // R3: no event and no clear leaves the pending bits untouched.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we_i && evt_i == '0) |=> $stable(pend_q));
endmodule

// File: rtl/apid_owner_summary.sv
// Builds the accumulated words: for each owner, bit s is the slot's
// any-pending AND enable AND owner match. ORs each owner's words into a level
// interrupt. Assumes words are packed 32 slots per group, padding bits zero.
module apid_owner_summary #(
    parameter int N_SLOT  = 64,
    parameter int N_OWNER = 8,
    parameter int OWN_W   = 3,
    parameter int GW      = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SLOT-1:0]         pend_any,
    input  logic [N_SLOT-1:0]         en,
    input  logic [N_SLOT*OWN_W-1:0]   own_flat,
    output logic [N_OWNER*GW-1:0]     acc_flat,
    output logic [N_OWNER-1:0]        irq
);
    for (genvar m = 0; m < N_OWNER; m++) begin : g_owner
        for (genvar s = 0; s < GW; s++) begin : g_bit
            if (s < N_SLOT) begin : g_live
                // Summary bit of slot s routed to owner m.
                assign acc_flat[m*GW + s] = pend_any[s] & en[s] &
                    (own_flat[s*OWN_W +: OWN_W] == OWN_W'(m));
            end else begin : g_pad
                assign acc_flat[m*GW + s] = 1'b0;
            end
        end
        // Level interrupt of owner m.
        assign irq[m] = |acc_flat[m*GW +: GW];
    end

    for (genvar s = 0; s < N_SLOT; s++) begin : g_col
        logic [N_OWNER-1:0] col;
        for (genvar m = 0; m < N_OWNER; m++) begin : g_c
            assign col[m] = acc_flat[m*GW + s];
        end
        // R7: a slot shows up in at most one owner's words.
        a_r7_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col));
    end

    // R8: an interrupt can only be raised through an enabled slot.
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |-> (|en));
endmodule

// File: rtl/apid_irq_accum.sv
// Top: per-peripheral interrupt accumulator. Instantiates the decoder, one
// cell per slot and the owner summary, and muxes register read-back.
// Assumes N_SLOT <= 256 and N_OWNER <= 8; reads are combinational.
module apid_irq_accum
    import apid_irq_pkg::*;
#(
    parameter int N_SLOT  = 64,
    parameter int N_OWNER = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_SLOT*SRC_BITS-1:0] evt_pulse,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    output logic [N_OWNER-1:0]         irq_out
);
    localparam int OWN_W   = (N_OWNER > 1) ? $clog2(N_OWNER) : 1;
    localparam int SLOT_W  = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;
    localparam int N_GROUP = (N_SLOT + GROUP_BITS - 1) / GROUP_BITS;
    localparam int GW      = N_GROUP * GROUP_BITS;

    region_e           region;
    logic [7:0]        slot_idx;
    logic              slot_ok;
    logic [OWN_W-1:0]  acc_owner;
    logic [2:0]        acc_group;
    logic              group_ok;
    logic [SLOT_W-1:0] slot_sel;

    logic [N_SLOT*SRC_BITS-1:0] pend_flat;
    logic [N_SLOT-1:0]          pend_any;
    logic [N_SLOT-1:0]          en_vec;
    logic [N_SLOT*OWN_W-1:0]    own_flat;
    logic [N_OWNER*GW-1:0]      acc_flat;

    apid_reg_decode #(.N_SLOT(N_SLOT), .N_OWNER(N_OWNER)) u_dec (
        .addr      (reg_addr),
        .region    (region),
        .slot_idx  (slot_idx),
        .slot_ok   (slot_ok),
        .acc_owner (acc_owner),
        .acc_group (acc_group),
        .group_ok  (group_ok)
    );

    assign slot_sel = slot_idx[SLOT_W-1:0];

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        logic hit;
        // Write strobe targets this slot.
        assign hit = reg_wr && slot_ok && (slot_sel == SLOT_W'(s));

        apid_slot_cell #(.SRC_BITS(SRC_BITS), .OWN_W(OWN_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_pulse[s*SRC_BITS +: SRC_BITS]),
            .clr_we_i (hit && region == RGN_CLR),
            .en_we_i  (hit && region == RGN_EN),
            .own_we_i (hit && region == RGN_OWN),
            .wdata_i  (reg_wdata),
            .pend_o   (pend_flat[s*SRC_BITS +: SRC_BITS]),
            .en_o     (en_vec[s]),
            .own_o    (own_flat[s*OWN_W +: OWN_W])
        );
        assign pend_any[s] = |pend_flat[s*SRC_BITS +: SRC_BITS];
    end

    apid_owner_summary #(.N_SLOT(N_SLOT), .N_OWNER(N_OWNER), .OWN_W(OWN_W), .GW(GW)) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_any (pend_any),
        .en       (en_vec),
        .own_flat (own_flat),
        .acc_flat (acc_flat),
        .irq      (irq_out)
    );

    // Register read-back mux; unmapped or out-of-range reads return 0 (R10).
    always_comb begin
        int base;
        reg_rdata = '0;
        base      = 0;
        unique case (region)
            RGN_ACC: if (group_ok) begin
                base = int'(acc_owner) * GW + int'(acc_group) * GROUP_BITS;
                reg_rdata = acc_flat[base +: GROUP_BITS];
            end
            RGN_EN:   if (slot_ok) reg_rdata = {31'b0, en_vec[slot_sel]};
            RGN_STAT: if (slot_ok) reg_rdata = {{(32-SRC_BITS){1'b0}},
                                                pend_flat[int'(slot_sel)*SRC_BITS +: SRC_BITS]};
            RGN_OWN:  if (slot_ok) reg_rdata = {{(32-OWN_W){1'b0}},
                                                own_flat[int'(slot_sel)*OWN_W +: OWN_W]};
            default:  reg_rdata = '0;
        endcase
    end

    // R1: one reset cycle leaves every interrupt output low.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0));
endmodule

// File: tb/sim_apid_irq_accum.sv
module sim_apid_irq_accum;
    localparam int CLK_PERIOD = 10;
    localparam int N_SLOT  = 64;
    localparam int N_OWNER = 8;

    localparam logic [1:0] K_WR = 2'd0, K_EV = 2'd1, K_RD = 2'd2, K_IRQ = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [12:0] addr;   // address, or slot number for events
        logic [31:0] data;   // write data or event bits
        logic [31:0] expv;   // expected read data or irq_out
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{K_RD,  13'h614, 32'h0,    32'h0,   4'd1},  // R1 status zero after reset
        '{K_EV,  13'd5,   32'h21,   32'h0,   4'd2},
        '{K_RD,  13'h614, 32'h0,    32'h21,  4'd2},  // R2 pulse bits stick
        '{K_IRQ, 13'h0,   32'h0,    32'h0,   4'd7},  // R7 disabled slot silent
        '{K_WR,  13'h214, 32'h1,    32'h0,   4'd5},
        '{K_RD,  13'h214, 32'h0,    32'h1,   4'd5},  // R5 enable readback
        '{K_RD,  13'h000, 32'h0,    32'h20,  4'd7},  // R7 owner0 group0 bit5
        '{K_IRQ, 13'h0,   32'h0,    32'h01,  4'd8},  // R8
        '{K_WR,  13'hE14, 32'h3,    32'h0,   4'd6},
        '{K_RD,  13'hE14, 32'h0,    32'h3,   4'd6},  // R6 owner readback
        '{K_RD,  13'h000, 32'h0,    32'h0,   4'd7},  // R7 moved away from owner0
        '{K_RD,  13'h060, 32'h0,    32'h20,  4'd7},  // R7 owner3 group0
        '{K_IRQ, 13'h0,   32'h0,    32'h08,  4'd8},  // R8
        '{K_EV,  13'd40,  32'h80,   32'h0,   4'd2},
        '{K_WR,  13'h2A0, 32'h1,    32'h0,   4'd5},
        '{K_RD,  13'h004, 32'h0,    32'h100, 4'd7},  // R7 slot40 = group1 bit8
        '{K_IRQ, 13'h0,   32'h0,    32'h09,  4'd8},  // R8 two owners
        '{K_WR,  13'h614, 32'h1,    32'h0,   4'd9},
        '{K_RD,  13'h614, 32'h0,    32'h21,  4'd9},  // R9 status write ignored
        '{K_WR,  13'hA14, 32'h1,    32'h0,   4'd3},
        '{K_RD,  13'h614, 32'h0,    32'h20,  4'd3},  // R3 partial clear
        '{K_WR,  13'hA14, 32'h20,   32'h0,   4'd3},
        '{K_IRQ, 13'h0,   32'h0,    32'h01,  4'd3},  // R3 full clear drops owner3
        '{K_WR,  13'h004, 32'hFFFF, 32'h0,   4'd9},
        '{K_RD,  13'h004, 32'h0,    32'h100, 4'd9},  // R9 acc write ignored
        '{K_RD,  13'hFFC, 32'h0,    32'h0,   4'd10}  // R10 owner slot beyond range
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [N_SLOT*8-1:0]    evt_pulse = '0;
    logic                   reg_wr = 1'b0;
    logic [12:0]            reg_addr = '0;
    logic [31:0]            reg_wdata = '0;
    logic [31:0]            reg_rdata;
    logic [N_OWNER-1:0]     irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    apid_irq_accum #(.N_SLOT(N_SLOT), .N_OWNER(N_OWNER)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ev(input int slot, input logic [7:0] bits);
        @(negedge clk);
        evt_pulse[slot*8 +: 8] = bits;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic rd_chk(input logic [12:0] a, input logic [31:0] expv, input int req);
        @(negedge clk);
        reg_addr = a;
        #1 check(req, reg_rdata, expv);
    endtask

    task automatic report;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check(1, 32'(irq_out), 32'h0);                 // R1 irq low after reset

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].kind)
                K_WR:  wr(VEC[i].addr, VEC[i].data);
                K_EV:  ev(int'(VEC[i].addr), VEC[i].data[7:0]);
                K_RD:  rd_chk(VEC[i].addr, VEC[i].expv, int'(VEC[i].req));
                default: begin
                    @(negedge clk);
                    #1 check(int'(VEC[i].req), 32'(irq_out), VEC[i].expv);
                end
            endcase
        end

        // R10: accumulated group past the last one reads zero.
        rd_chk(13'h008, 32'h0, 10);
        // R10: clear register reads zero.
        rd_chk(13'hA14, 32'h0, 10);

        // R5: disabling slot 40 drops owner0 but keeps its pending bits.
        wr(13'h2A0, 32'h0);
        @(negedge clk);
        #1 check(8, 32'(irq_out), 32'h0);                 // R8
        rd_chk(13'h6A0, 32'h80, 5);                       // R5

        // R4: event and clear on the same bit in the same cycle: set wins.
        ev(7, 8'h04);
        @(negedge clk);
        evt_pulse[7*8 +: 8] = 8'h04;
        reg_wr = 1'b1; reg_addr = 13'hA1C; reg_wdata = 32'h04;
        @(negedge clk);
        evt_pulse = '0; reg_wr = 1'b0;
        rd_chk(13'h61C, 32'h04, 4);                       // R4

        // R1: mid-run reset wipes pending, enable and owner state.
        wr(13'h21C, 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check(1, 32'(irq_out), 32'h0);                 // R1
        rd_chk(13'h61C, 32'h0, 1);                        // R1 pending
        rd_chk(13'h21C, 32'h0, 1);                        // R1 enable
        rd_chk(13'hE14, 32'h0, 1);                        // R1 owner

        done = 1;
        report();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end
endmodule